// File: doc/BRIEF.md
# Multi-Band Biquad Equalizer Engine

This block equalizes a stream of audio samples. Each sample arrives with a channel index. For that channel the block applies a gain stage, then a run-time-selected number of biquad filter sections in cascade, then a closing gain stage. Every stage ends with a programmable arithmetic right shift and saturation back to 32 bits. Coefficients and shift amounts come from two external per-channel parameter memories, which the block addresses itself and reads combinationally. Each band of each channel keeps its own delay history.

A single multiply-accumulate unit is shared in time across all stages. A gain stage takes one cycle and a band takes five, so a sample with N bands finishes 2 + 5·N cycles after it is accepted. The sample interface accepts one sample at a time with a valid/ready handshake. The next sample is taken only after the previous result has been consumed. When the enable input is low the block forwards samples unchanged.

Top module: `eq_biquad_engine`

## Requirements
- R1: With `cfg_active` low, an accepted sample appears on `out_data` unchanged, with its channel on `out_chan`, one cycle after acceptance.
- R2: The first stage computes sat32((g·x) >>> s), where g is coefficient word 0 of the channel and s is shift word 0.
- R3: Band k (0-based) computes sat32((b0·x + b1·x1 + b2·x2 + a1·y1 + a2·y2) >>> s). The coefficients are words 1+5k .. 5+5k in that order, the feedback terms are added with their stored sign, and s is shift word 1+k. A band with b0=1, all other terms 0 and shift 0 passes its input through.
- R4: The number of bands used is `cfg_bands_m1`+1, and a value above 11 means all twelve. Bands past the count are neither applied nor have their history advanced.
- R5: The last stage computes sat32((p·v) >>> s) on the cascade output v, with p = coefficient word 61 and s = shift word 13.
- R6: Every stage result is clamped to the range −2^31 .. 2^31−1.
- R7: Channel c reads coefficient addresses 62·c .. 62·c+61 and shift addresses 14·c .. 14·c+13, and it keeps a delay history separate from every other channel.
- R8: When `cfg_active` changes from low to high, all delay history of all channels and bands is cleared.
- R9: `in_ready` is low from acceptance until the result has been taken. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold.
- R10: After reset, `out_valid` is low, `in_ready` is high and all delay history is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_active | input | 1 | 1 = filter, 0 = forward unchanged |
| cfg_bands_m1 | input | 4 | Active band count minus one |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_chan | input | 3 | Channel of input sample |
| in_data | input | 32 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_chan | output | 3 | Channel of result |
| out_data | output | 32 | Signed result |
| coef_addr | output | 9 | Coefficient memory word address |
| coef_data | input | 32 | Signed coefficient read data |
| shift_addr | output | 7 | Shift memory word address |
| shift_data | input | 5 | Shift amount read data |

## Verification
The bench aims at the places where a time-shared datapath usually breaks. A wrong tap-to-operand mapping, or feedback terms applied with the wrong sign, gives results that drift from the model after the first few samples of a channel. An off-by-one in the band count, or in the clamp for oversized count values, runs one band too many or too few, which changes both the current output and the history seen later. Saturation is driven to both rails, where a design without the clamp wraps to the opposite sign. Re-enabling after bypass is followed by samples whose expected values assume empty history, and held back-pressure tests that a result is neither lost nor changed while it waits.

// File: rtl/eq_pkg.sv
// Package: shared types for the biquad equalizer engine.
// Assumes: nothing beyond IEEE 1800-2017.
package eq_pkg;
    // Which delay term a band tap multiplies
    typedef enum logic [2:0] {
        OP_CUR = 3'd0,
        OP_X1  = 3'd1,
        OP_X2  = 3'd2,
        OP_Y1  = 3'd3,
        OP_Y2  = 3'd4
    } eq_operand_t;

    // Number of coefficients consumed by one band
    localparam int TAPS_PER_BAND = 5;
endpackage

// File: rtl/eq_sequencer.sv
// Module: eq_sequencer
// Steps one sample through pre-gain, N bands of five taps each, and
// post-gain, and produces the parameter memory addresses for each cycle.
// Assumes: start is pulsed only when running is low; chan is held for
// the whole sample.
module eq_sequencer #(
    parameter int CHANNELS = 8,
    parameter int BANDS    = 12,
    parameter int CHW      = $clog2(CHANNELS),
    parameter int BW       = $clog2(BANDS),
    parameter int SW       = $clog2(BANDS + 2),
    parameter int CAW      = $clog2(CHANNELS * (eq_pkg::TAPS_PER_BAND * BANDS + 2)),
    parameter int SAW      = $clog2(CHANNELS * (BANDS + 2))
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [BW-1:0]  nbands_m1,
    input  logic [CHW-1:0] chan,
    output logic           running,
    output logic           last_tap,
    output logic           is_band,
    output logic           is_post,
    output logic [BW-1:0]  band,
    output logic [2:0]     tap,
    output logic [CAW-1:0] coef_addr,
    output logic [SAW-1:0] shift_addr
);
    localparam int CPC = eq_pkg::TAPS_PER_BAND * BANDS + 2;
    localparam int SPC = BANDS + 2;

    logic [SW-1:0] stage;
    logic [SW-1:0] nb_q;
    logic [SW-1:0] nb_eff;
    logic          is_pre;
    logic [CAW-1:0] coef_off;
    logic [SAW-1:0] shift_off;

    // Clamp the band count field to the number of bands that exist
    always_comb begin
        if (int'(nbands_m1) >= BANDS) nb_eff = SW'(BANDS);
        else                          nb_eff = SW'(nbands_m1) + SW'(1);
    end

    // Decode the current stage
    always_comb begin
        is_pre   = (stage == '0);
        is_post  = (stage == nb_q + SW'(1));
        is_band  = !is_pre && !is_post;
        band     = BW'(stage - SW'(1));
        last_tap = is_band ? (tap == 3'(eq_pkg::TAPS_PER_BAND - 1)) : 1'b1;
    end

    // Form the parameter memory addresses for this cycle
    always_comb begin
        if (is_pre)       coef_off = '0;
        else if (is_post) coef_off = CAW'(CPC - 1);
        else              coef_off = CAW'(1) + CAW'(band) * CAW'(eq_pkg::TAPS_PER_BAND) + CAW'(tap);
        shift_off  = is_post ? SAW'(SPC - 1) : SAW'(stage);
        coef_addr  = CAW'(chan) * CAW'(CPC) + coef_off;
        shift_addr = SAW'(chan) * SAW'(SPC) + shift_off;
    end

    // Advance tap and stage counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            stage   <= '0;
            tap     <= '0;
            nb_q    <= '0;
        end else if (start) begin
            running <= 1'b1;
            stage   <= '0;
            tap     <= '0;
            nb_q    <= nb_eff;
        end else if (running) begin
            if (last_tap) begin
                tap <= '0;
                if (is_post) running <= 1'b0;
                else         stage   <= stage + SW'(1);
            end else begin
                tap <= tap + 3'd1;
            end
        end
    end

    // Checker counter: cycles spent on the current sample
    logic [9:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || start) run_cnt <= '0;
        else if (running)    run_cnt <= run_cnt + 10'd1;
    end

    // R4: a sample takes exactly 2 + 5 * band count cycles
    p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && last_tap && is_post) |->
            (run_cnt + 10'd1 == 10'd2 + 10'(eq_pkg::TAPS_PER_BAND) * 10'(nb_q)));

    // R7: addresses stay inside the parameter memories
    p_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (int'(coef_addr) < CHANNELS * CPC && int'(shift_addr) < CHANNELS * SPC));
endmodule

// File: rtl/eq_mac.sv
// Module: eq_mac
// Shared multiply-accumulate unit. Accumulates coef*operand in a 64-bit
// register; on the last tap of a stage it shifts, saturates and clears.
// Assumes: shift is at most 31; accumulator overflow past 64 bits wraps.
module eq_mac #(
    parameter int DW = 32,
    parameter int AW = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 last,
    input  logic signed [DW-1:0] coef,
    input  logic signed [DW-1:0] operand,
    input  logic [4:0]           shift,
    output logic signed [DW-1:0] result
);
    localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] prod;
    logic signed [AW-1:0] acc_next;
    logic signed [AW-1:0] shifted;

    // Multiply, add and scale the running sum
    always_comb begin
        prod     = AW'(coef) * AW'(operand);
        acc_next = acc + prod;
        shifted  = acc_next >>> shift;
        if (shifted > MAXV)      result = MAXV[DW-1:0];
        else if (shifted < MINV) result = MINV[DW-1:0];
        else                     result = shifted[DW-1:0];
    end

    // Hold the partial sum between taps of one stage
    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= last ? '0 : acc_next;
    end

    // R6: a stage boundary always starts the next stage from zero
    p_acc_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last) |=> (acc == '0));
endmodule

// File: rtl/eq_state_store.sv
// Module: eq_state_store
// Delay history (x1, x2, y1, y2) for every channel/band pair.
// Assumes: one read/write index per cycle; clear wins over write.
module eq_state_store #(
    parameter int DW      = 32,
    parameter int ENTRIES = 96,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [IW-1:0]        idx,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_x,
    input  logic signed [DW-1:0] wr_y,
    output logic signed [DW-1:0] x1,
    output logic signed [DW-1:0] x2,
    output logic signed [DW-1:0] y1,
    output logic signed [DW-1:0] y2
);
    logic signed [DW-1:0] mx1 [ENTRIES];
    logic signed [DW-1:0] mx2 [ENTRIES];
    logic signed [DW-1:0] my1 [ENTRIES];
    logic signed [DW-1:0] my2 [ENTRIES];

    // Read the history of the selected band
    always_comb begin
        x1 = mx1[idx];
        x2 = mx2[idx];
        y1 = my1[idx];
        y2 = my2[idx];
    end

    // Clear all history or shift in the newest input/output pair
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mx1[i] <= '0;
                mx2[i] <= '0;
                my1[i] <= '0;
                my2[i] <= '0;
            end
        end else if (wr_en) begin
            mx2[idx] <= mx1[idx];
            mx1[idx] <= wr_x;
            my2[idx] <= my1[idx];
            my1[idx] <= wr_y;
        end
    end

    // R8: after a clear, the first entry's history reads back as zero
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mx1[0] == '0 && mx2[0] == '0 && my1[0] == '0 && my2[0] == '0));
endmodule

// File: rtl/eq_biquad_engine.sv
// Module: eq_biquad_engine (top)
// Multi-channel equalizer: pre-gain, cascaded biquads, post-gain, each
// with its own right shift, on one time-shared MAC.
// Assumes: parameter memories answer combinationally; cfg_active changes
// only while no sample is in flight.
module eq_biquad_engine #(
    parameter int CHANNELS = 8,
    parameter int BANDS    = 12,
    parameter int DW       = 32,
    parameter int CHW      = $clog2(CHANNELS),
    parameter int BW       = $clog2(BANDS),
    parameter int CAW      = $clog2(CHANNELS * (5 * BANDS + 2)),
    parameter int SAW      = $clog2(CHANNELS * (BANDS + 2))
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_active,
    input  logic [BW-1:0]        cfg_bands_m1,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CHW-1:0]       in_chan,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [CHW-1:0]       out_chan,
    output logic signed [DW-1:0] out_data,
    output logic [CAW-1:0]       coef_addr,
    input  logic signed [DW-1:0] coef_data,
    output logic [SAW-1:0]       shift_addr,
    input  logic [4:0]           shift_data
);
    localparam int ENTRIES = CHANNELS * BANDS;
    localparam int IW      = $clog2(ENTRIES);

    logic                 accept;
    logic                 start;
    logic                 running;
    logic                 last_tap;
    logic                 is_band;
    logic                 is_post;
    logic [BW-1:0]        band;
    logic [2:0]           tap;
    logic [CHW-1:0]       chan_q;
    logic signed [DW-1:0] cur;
    logic signed [DW-1:0] operand;
    logic signed [DW-1:0] result;
    logic signed [DW-1:0] hx1, hx2, hy1, hy2;
    logic                 act_q;
    logic                 clear_hist;
    logic [IW-1:0]        hist_idx;
    logic                 stage_done;

    assign in_ready   = !running && !out_valid;
    assign accept     = in_valid && in_ready;
    assign start      = accept && cfg_active;
    assign stage_done = running && last_tap;
    assign clear_hist = cfg_active && !act_q;
    assign hist_idx   = IW'(chan_q) * IW'(BANDS) + IW'(band);

    eq_sequencer #(
        .CHANNELS (CHANNELS),
        .BANDS    (BANDS),
        .CHW      (CHW),
        .BW       (BW),
        .CAW      (CAW),
        .SAW      (SAW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .nbands_m1  (cfg_bands_m1),
        .chan       (chan_q),
        .running    (running),
        .last_tap   (last_tap),
        .is_band    (is_band),
        .is_post    (is_post),
        .band       (band),
        .tap        (tap),
        .coef_addr  (coef_addr),
        .shift_addr (shift_addr)
    );

    eq_state_store #(
        .DW      (DW),
        .ENTRIES (ENTRIES),
        .IW      (IW)
    ) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_hist),
        .idx   (hist_idx),
        .wr_en (stage_done && is_band),
        .wr_x  (cur),
        .wr_y  (result),
        .x1    (hx1),
        .x2    (hx2),
        .y1    (hy1),
        .y2    (hy2)
    );

    eq_mac #(
        .DW (DW),
        .AW (64)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (running),
        .last    (last_tap),
        .coef    (coef_data),
        .operand (operand),
        .shift   (shift_data),
        .result  (result)
    );

    // Pick the multiplicand for the current tap
    always_comb begin
        operand = cur;
        if (is_band) begin
            case (eq_pkg::eq_operand_t'(tap))
                eq_pkg::OP_X1: operand = hx1;
                eq_pkg::OP_X2: operand = hx2;
                eq_pkg::OP_Y1: operand = hy1;
                eq_pkg::OP_Y2: operand = hy2;
                default:       operand = cur;
            endcase
        end
    end

    // Track the enable bit to spot a bypass-to-active change
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= cfg_active;
    end

    // Capture the sample and carry each stage result to the next stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            cur    <= '0;
        end else if (accept) begin
            chan_q <= in_chan;
            cur    <= in_data;
        end else if (stage_done) begin
            cur    <= result;
        end
    end

    // Present the result and hold it until taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else if (accept && !cfg_active) begin
            out_valid <= 1'b1;
            out_chan  <= in_chan;
            out_data  <= in_data;
        end else if (stage_done && is_post) begin
            out_valid <= 1'b1;
            out_chan  <= chan_q;
            out_data  <= result;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R1: a sample taken in bypass comes out unchanged next cycle
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_active) |=> (out_valid && out_data == $past(in_data)));

    // R9: a result waiting on the consumer holds still
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

    // R9: no second sample is taken right after one is accepted
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/eq_biquad_engine_tb.sv
module eq_biquad_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CH  = 8;
    localparam int NB  = 12;
    localparam int CPC = 5 * NB + 2;
    localparam int SPC = NB + 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_active = 1'b1;
    logic [3:0]         cfg_bands_m1 = 4'd11;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [2:0]         in_chan = '0;
    logic signed [31:0] in_data = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [2:0]         out_chan;
    logic signed [31:0] out_data;
    logic [8:0]         coef_addr;
    logic signed [31:0] coef_data;
    logic [6:0]         shift_addr;
    logic [4:0]         shift_data;

    logic signed [31:0] coef_mem [CH*CPC];
    logic [4:0]         shift_mem [CH*SPC];
    logic signed [31:0] rx1 [CH*NB];
    logic signed [31:0] rx2 [CH*NB];
    logic signed [31:0] ry1 [CH*NB];
    logic signed [31:0] ry2 [CH*NB];

    int n_tests = 0;
    int n_fail  = 0;

    assign coef_data  = coef_mem[int'(coef_addr)];
    assign shift_data = shift_mem[int'(shift_addr)];

    always #(CLK_PERIOD/2) clk = ~clk;

    eq_biquad_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_bands_m1(cfg_bands_m1),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data),
        .coef_addr(coef_addr), .coef_data(coef_data), .shift_addr(shift_addr), .shift_data(shift_data)
    );

    function automatic logic signed [31:0] sat(longint v);
        if (v > 64'sd2147483647)       return 32'sh7FFFFFFF;
        else if (v < -64'sd2147483648) return 32'sh80000000;
        else                           return v[31:0];
    endfunction

    function automatic logic signed [31:0] rs(int bits);
        return $signed($urandom) >>> (32 - bits);
    endfunction

    function automatic void ref_clear();
        for (int i = 0; i < CH*NB; i++) begin
            rx1[i] = 0; rx2[i] = 0; ry1[i] = 0; ry2[i] = 0;
        end
    endfunction

    // Independent model: pre-gain, nb bands, post-gain (R2..R7)
    function automatic logic signed [31:0] ref_run(int ch, logic signed [31:0] x, int m1);
        int nb = (m1 >= NB) ? NB : m1 + 1;
        int cb = ch * CPC;
        int sb = ch * SPC;
        logic signed [31:0] v;
        logic signed [31:0] y;
        longint acc;
        v = sat((longint'(coef_mem[cb]) * longint'(x)) >>> shift_mem[sb]);
        for (int k = 0; k < nb; k++) begin
            int e = ch * NB + k;
            int a = cb + 1 + 5 * k;
            acc = longint'(coef_mem[a])   * longint'(v)
                + longint'(coef_mem[a+1]) * longint'(rx1[e])
                + longint'(coef_mem[a+2]) * longint'(rx2[e])
                + longint'(coef_mem[a+3]) * longint'(ry1[e])
                + longint'(coef_mem[a+4]) * longint'(ry2[e]);
            y = sat(acc >>> shift_mem[sb + 1 + k]);
            rx2[e] = rx1[e]; rx1[e] = v;
            ry2[e] = ry1[e]; ry1[e] = y;
            v = y;
        end
        return sat((longint'(coef_mem[cb + CPC - 1]) * longint'(v)) >>> shift_mem[sb + SPC - 1]);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_identity(int ch);
        for (int i = 0; i < CPC; i++) coef_mem[ch*CPC + i] = 0;
        coef_mem[ch*CPC] = 1;
        coef_mem[ch*CPC + CPC - 1] = 1;
        for (int k = 0; k < NB; k++) coef_mem[ch*CPC + 1 + 5*k] = 1;
        for (int i = 0; i < SPC; i++) shift_mem[ch*SPC + i] = 0;
    endtask

    task automatic load_random(int ch);
        coef_mem[ch*CPC] = rs(16);
        coef_mem[ch*CPC + CPC - 1] = rs(16);
        for (int k = 0; k < NB; k++) begin
            int a = ch*CPC + 1 + 5*k;
            coef_mem[a]   = rs(15);
            coef_mem[a+1] = rs(15);
            coef_mem[a+2] = rs(15);
            coef_mem[a+3] = rs(13);
            coef_mem[a+4] = rs(13);
        end
        for (int i = 0; i < SPC; i++) shift_mem[ch*SPC + i] = 5'd14;
    endtask

    // Offer one sample and wait for its result (out_ready must be high)
    task automatic send(int ch, logic signed [31:0] x, output logic signed [31:0] got, output logic [2:0] gch);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_chan = 3'(ch); in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        got = out_data; gch = out_chan;
        @(negedge clk);
    endtask

    task automatic run_check(string req, int ch, logic signed [31:0] x);
        logic signed [31:0] got;
        logic [2:0] gch;
        logic signed [31:0] exp;
        exp = cfg_active ? ref_run(ch, x, int'(cfg_bands_m1)) : x;
        send(ch, x, got, gch);
        chk(req, got, exp);
        chk({req, " chan"}, 32'(gch), 32'(ch));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < CH; c++) load_identity(c);
        ref_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 in_ready", 32'(in_ready), 32'd1);
        chk("R10 out_valid", 32'(out_valid), 32'd0);

        // R3: identity bands pass every channel through
        for (int c = 0; c < CH; c++) run_check("R3 identity", c, rs(32));

        // R2 R3 R5 R7: random parameters, channels and band counts
        for (int c = 0; c < CH; c++) load_random(c);
        for (int n = 0; n < 160; n++) begin
            cfg_bands_m1 = 4'($urandom_range(0, 11));
            run_check("R2/R3/R5/R7 random", int'($urandom_range(0, CH-1)), rs(25));
        end
        // R4: band count edges and oversized field
        cfg_bands_m1 = 4'd0;
        for (int n = 0; n < 6; n++) run_check("R4 one band", 2, rs(25));
        cfg_bands_m1 = 4'd15;
        for (int n = 0; n < 6; n++) run_check("R4 clamp", 5, rs(25));

        // R1: bypass forwards unchanged
        cfg_active = 1'b0;
        for (int n = 0; n < 6; n++) run_check("R1 bypass", int'($urandom_range(0, CH-1)), rs(32));
        // R8: re-enable clears history
        cfg_active = 1'b1;
        @(negedge clk); @(negedge clk);
        ref_clear();
        cfg_bands_m1 = 4'd11;
        for (int n = 0; n < 6; n++) run_check("R8 cleared history", 4, rs(25));

        // R6: saturation at both rails
        load_identity(3);
        coef_mem[3*CPC] = 32'sh7FFFFFFF;
        run_check("R6 sat high", 3, 32'sh40000000);
        run_check("R6 sat low", 3, -32'sh40000000);

        // R9: back-pressure holds the result
        begin
            logic signed [31:0] exp;
            logic signed [31:0] held;
            exp = ref_run(6, 32'sh00012345, int'(cfg_bands_m1));
            out_ready = 1'b0;
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_chan = 3'd6; in_data = 32'sh00012345;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R9 busy", 32'(in_ready), 32'd0);
            while (!out_valid) @(negedge clk);
            held = out_data;
            chk("R9 value", held, exp);
            for (int n = 0; n < 4; n++) begin
                @(negedge clk);
                chk("R9 hold valid", 32'(out_valid), 32'd1);
                chk("R9 hold data", out_data, held);
                chk("R9 no accept", 32'(in_ready), 32'd0);
            end
            out_ready = 1'b1;
            @(negedge clk);
            chk("R9 release", 32'(out_valid), 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule